// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a three-line serial control port. It sits between a shared host bus (serial clock, chip select, one data line) and the core of a device that holds its settings in a small bank of eight-bit registers. The host selects the device, shifts in a register address and a direction bit, and then either shifts in a full data byte to store or clocks out the addressed byte on the same data line. The pad holds the data line as an input until the port sets the output enable.

The bank has 23 locations. The lower 22 are configuration registers that the host can write and read, and all of them reach the core as parallel outputs. The top location is a status byte that the core supplies and the host can only read. After reset the configuration selects the power-down operating mode. The port stays inert whenever chip select is high, so other devices can share the clock and data lines.

The bus pins are sampled by the block's own system clock through a synchronizer. Each serial clock half-period must therefore last several system clock cycles.

Top module: `ctl3w_port`

## Requirements
- R1: While reset is held and after it is released, every configuration register reads 0x00. This puts the operating-mode field (register 1, bits 2:1) at 00, which is power-down, and leaves the data-line output enable low.
- R2: A frame starts when cs_n goes low. It carries 7 address bits (most significant first), then one direction bit (1 = read, 0 = write), then 8 data bits (most significant first). The port samples sdi on rising sclk edges.
- R3: A complete write frame to an address from 0 to 21 stores the byte in that register only. All other registers keep their values.
- R4: In a read frame, the port drives the addressed register's byte on sdo, most significant bit first. Each bit changes after a falling sclk edge, so the host can sample it at the next rising edge.
- R5: A read of address 22 returns the current status_in byte. A write to address 22 changes no register.
- R6: A write to an address from 23 to 127 changes no register. A read from such an address returns 0x00.
- R7: If cs_n rises before the eighth data bit of a write frame is sampled, no register changes.
- R8: sdo_en is high only during the eight data bits of a read frame while cs_n is low. It is low at all other times.
- R9: While cs_n is high, sclk and sdi activity changes no register and does not raise sdo_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Data line as seen by the input buffer |
| sdo | output | 1 | Value to drive on the data line |
| sdo_en | output | 1 | Output enable of the data-line pad |
| status_in | input | 8 | Status byte returned at address 22 |
| cfg_regs | output | 176 | Registers 0..21, register n at bits 8n+7:8n |

## Verification
On every cycle, the assertions check the following:
- the output enable is only ever raised inside a selected read frame;
- the bit counter is held at zero while the port is deselected and never passes the frame length;
- the register outputs move only in the cycle after a commit to an in-range address.

Only the bench scenarios can show the remaining behaviour:
- the bit ordering of address and data;
- that read-back data equals what was written or supplied as status;
- that an aborted frame or traffic while deselected leaves the bank intact.

The bench shows these by comparing the whole register bank and every read byte against its own model after each frame.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 23;

  // operating-mode field location and its power-down code
  localparam int          MODE_REG = 1;
  localparam int          MODE_LSB = 1;
  localparam logic [1:0]  MODE_PWRDN = 2'b00;

  function automatic logic [DATA_W-1:0] cfg_default(input int idx);
    logic [DATA_W-1:0] v;
    v = '0;
    if (idx == MODE_REG) v[MODE_LSB +: 2] = MODE_PWRDN;
    return v;
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync (
  input  logic clk,
  input  logic rst_an,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic rst_ns,
  output logic sel,
  output logic din,
  output logic rise,
  output logic fall
);
  logic [1:0] rst_q;
  logic [2:0] sck_q;
  logic [1:0] cs_q;
  logic [1:0] dat_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ns = rst_q[1];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sck_q <= 3'b000;
      cs_q  <= 2'b11;
      dat_q <= 2'b00;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      cs_q  <= {cs_q[0], cs_n};
      dat_q <= {dat_q[0], sdi};
    end
  end

  assign sel  = ~cs_q[1];
  assign din  = dat_q[1];
  assign rise = sck_q[1] & ~sck_q[2];
  assign fall = ~sck_q[1] & sck_q[2];
endmodule

// File: rtl/ctl3w_frame.sv
module ctl3w_frame #(
  parameter int AW = 7,
  parameter int DW = 8,
  localparam int FLEN = AW + 1 + DW,
  localparam int CW   = $clog2(FLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rise,
  input  logic          fall,
  input  logic          din,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr,
  output logic          rd_mode,
  output logic [CW-1:0] cnt,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          sdo_en
);
  localparam logic [CW-1:0] C_RW   = CW'(AW);
  localparam logic [CW-1:0] C_D0   = CW'(AW + 1);
  localparam logic [CW-1:0] C_LAST = CW'(FLEN - 1);
  localparam logic [CW-1:0] C_END  = CW'(FLEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          rw_q, rw_d;
  logic [DW-1:0] in_q, in_d;
  logic [DW-1:0] out_q, out_d;
  logic          oe_q, oe_d;
  logic          stb_q, stb_d;
  logic [AW-1:0] wa_q, wa_d;
  logic [DW-1:0] wd_q, wd_d;

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    rw_d   = rw_q;
    in_d   = in_q;
    out_d  = out_q;
    oe_d   = oe_q;
    stb_d  = 1'b0;
    wa_d   = wa_q;
    wd_d   = wd_q;
    if (!sel) begin
      cnt_d = '0;
      rw_d  = 1'b0;
      oe_d  = 1'b0;
    end else begin
      if (rise && (cnt_q < C_END)) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q < C_RW) begin
          addr_d = {addr_q[AW-2:0], din};
        end else if (cnt_q == C_RW) begin
          rw_d = din;
          if (din) out_d = rd_data;
        end else begin
          in_d = {in_q[DW-2:0], din};
          if ((cnt_q == C_LAST) && !rw_q) begin
            stb_d = 1'b1;
            wa_d  = addr_q;
            wd_d  = {in_q[DW-2:0], din};
          end
        end
      end
      if (fall) begin
        oe_d = rw_q && (cnt_q >= C_D0) && (cnt_q < C_END);
        if (rw_q && (cnt_q > C_D0) && (cnt_q < C_END))
          out_d = {out_q[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
      rw_q   <= 1'b0;
      in_q   <= '0;
      out_q  <= '0;
      oe_q   <= 1'b0;
      stb_q  <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      rw_q   <= rw_d;
      in_q   <= in_d;
      out_q  <= out_d;
      oe_q   <= oe_d;
      stb_q  <= stb_d;
      wa_q   <= wa_d;
      wd_q   <= wd_d;
    end
  end

  assign addr    = addr_q;
  assign rd_mode = rw_q;
  assign cnt     = cnt_q;
  assign wr_stb  = stb_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign sdo     = out_q[DW-1];
  assign sdo_en  = oe_q & sel;
endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank #(
  parameter int AW   = 7,
  parameter int DW   = 8,
  parameter int NREG = 23,
  localparam int NWR = NREG - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  input  logic [DW-1:0]     status_in,
  output logic [DW-1:0]     rd_data,
  output logic [NWR*DW-1:0] cfg
);
  logic [DW-1:0] q [NWR];

  for (genvar i = 0; i < NWR; i++) begin : g_reg
    logic en;
    assign en = wr_stb && (wr_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= ctl3w_pkg::cfg_default(i);
      else if (en) q[i] <= wr_data;
    end
    assign cfg[i*DW +: DW] = q[i];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NWR; i++)
      if (rd_addr == AW'(i)) rd_data = q[i];
    if (rd_addr == AW'(NWR)) rd_data = status_in;
  end
endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port #(
  parameter int AW   = ctl3w_pkg::ADDR_W,
  parameter int DW   = ctl3w_pkg::DATA_W,
  parameter int NREG = ctl3w_pkg::NUM_REGS,
  localparam int NWR  = NREG - 1,
  localparam int FLEN = AW + 1 + DW,
  localparam int CW   = $clog2(FLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_en,
  input  logic [DW-1:0]     status_in,
  output logic [NWR*DW-1:0] cfg_regs
);
  logic          rst_ns, sel_s, din_s, rise_s, fall_s;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          rd_mode, wr_stb;
  logic [CW-1:0] bit_cnt;

  ctl3w_sync u_sync (
    .clk(clk), .rst_an(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .rst_ns(rst_ns), .sel(sel_s), .din(din_s), .rise(rise_s), .fall(fall_s)
  );

  ctl3w_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_ns), .sel(sel_s), .rise(rise_s), .fall(fall_s),
    .din(din_s), .rd_data(rd_data), .addr(rd_addr), .rd_mode(rd_mode),
    .cnt(bit_cnt), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  ctl3w_regbank #(.AW(AW), .DW(DW), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_ns), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .status_in(status_in),
    .rd_data(rd_data), .cfg(cfg_regs)
  );
endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk #(
  parameter int AW   = 7,
  parameter int DW   = 8,
  parameter int NREG = 23,
  localparam int NWR  = NREG - 1,
  localparam int FLEN = AW + 1 + DW,
  localparam int CW   = $clog2(FLEN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              sdo_en,
  input logic              rd_mode,
  input logic              wr_stb,
  input logic [AW-1:0]     wr_addr,
  input logic [CW-1:0]     cnt,
  input logic [NWR*DW-1:0] cfg
);
  // R8
  oe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> sel);
  // R8
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> rd_mode);
  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(cfg));
  // R6
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_addr >= AW'(NWR))) |=> $stable(cfg));
  // R9
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt == '0));
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FLEN));
endmodule

bind ctl3w_port ctl3w_chk #(.AW(AW), .DW(DW), .NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_ns), .sel(sel_s), .sdo_en(sdo_en), .rd_mode(rd_mode),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .cnt(bit_cnt), .cfg(cfg_regs)
);

// File: tb/ctl3w_port_tb.sv
module ctl3w_port_tb_top;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_en;
  logic [7:0] status_in = 8'h00;
  logic [175:0] cfg_regs;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [22];

  always #10 clk = ~clk;

  ctl3w_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .status_in(status_in), .cfg_regs(cfg_regs)
  );

  function automatic logic [175:0] model_flat();
    logic [175:0] v;
    for (int i = 0; i < 22; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    if (a < 7'd22) return model[a];
    if (a == 7'd22) return status_in;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [175:0] act, input logic [175:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame; nbits < 16 models an early chip-select release
  task automatic frame(input logic [6:0] a, input logic rw, input logic [7:0] wd,
                       input int nbits, output logic [7:0] rd, output int oe_bad);
    logic [15:0] bits;
    bits = {a, rw, wd};
    rd = 8'h00;
    oe_bad = 0;
    cs_n = 1'b0;
    hwait(H);
    for (int k = 0; k < nbits; k++) begin
      sclk = 1'b0;
      sdi = bits[15-k];
      hwait(H);
      if (k >= 8) begin
        rd = {rd[6:0], sdo};
        if (sdo_en !== rw) oe_bad++;
      end else if (sdo_en !== 1'b0) oe_bad++;
      sclk = 1'b1;
      hwait(H);
    end
    sclk = 1'b0;
    hwait(H);
    cs_n = 1'b1;
    hwait(H);
    if (sdo_en !== 1'b0) oe_bad++;
    if (nbits == 16 && !rw && a < 7'd22) model[a] = wd;
  endtask

  initial begin
    logic [7:0] rd;
    int oeb;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 22; i++) model[i] = 8'h00;
    hwait(2);
    // R1 during reset
    chk("R1 cfg in reset", cfg_regs, model_flat());
    chk("R1 oe in reset", {175'd0, sdo_en}, 176'd0);
    hwait(3);
    rst_n = 1'b1;
    hwait(6);
    chk("R1 cfg after reset", cfg_regs, model_flat());
    chk("R1 power-down mode field", {174'd0, cfg_regs[8+1 +: 2]}, 176'd0);

    // R2/R3 write then R4 read back
    frame(7'd5, 1'b0, 8'hA5, 16, rd, oeb);
    chk("R3 single write", cfg_regs, model_flat());
    frame(7'd5, 1'b1, 8'h00, 16, rd, oeb);
    chk("R4 read back", {168'd0, rd}, {168'd0, 8'hA5});
    chk("R8 oe window on read", {144'd0, 32'(oeb)}, 176'd0);
    // R2 address MSB first: 7'h01 is register 1, not 64
    frame(7'h01, 1'b0, 8'h81, 16, rd, oeb);
    chk("R2 address order", {168'd0, cfg_regs[15:8]}, {168'd0, 8'h81});
    frame(7'd21, 1'b0, 8'h3C, 16, rd, oeb);
    chk("R2 data order top register", cfg_regs, model_flat());
    chk("R8 oe low on write", {144'd0, 32'(oeb)}, 176'd0);

    // R5 status register
    status_in = 8'h6B;
    frame(7'd22, 1'b1, 8'h00, 16, rd, oeb);
    chk("R5 status read", {168'd0, rd}, {168'd0, 8'h6B});
    frame(7'd22, 1'b0, 8'hFF, 16, rd, oeb);
    chk("R5 write to status ignored", cfg_regs, model_flat());
    frame(7'd22, 1'b1, 8'h00, 16, rd, oeb);
    chk("R5 status unchanged", {168'd0, rd}, {168'd0, 8'h6B});

    // R6 out of range
    frame(7'h50, 1'b0, 8'hEE, 16, rd, oeb);
    chk("R6 oob write ignored", cfg_regs, model_flat());
    frame(7'd23, 1'b1, 8'h00, 16, rd, oeb);
    chk("R6 oob read zero", {168'd0, rd}, 176'd0);
    frame(7'h7F, 1'b1, 8'h00, 16, rd, oeb);
    chk("R6 top address read zero", {168'd0, rd}, 176'd0);

    // R7 aborted writes
    frame(7'd3, 1'b0, 8'h77, 12, rd, oeb);
    chk("R7 abort mid byte", cfg_regs, model_flat());
    frame(7'd3, 1'b0, 8'h77, 15, rd, oeb);
    chk("R7 abort before last bit", cfg_regs, model_flat());
    frame(7'd3, 1'b0, 8'h78, 16, rd, oeb);
    chk("R7 full frame after aborts", cfg_regs, model_flat());

    // R9 deselected traffic
    oeb = 0;
    for (int k = 0; k < 48; k++) begin
      sclk = ~sclk;
      sdi = 1'($urandom_range(0, 1));
      hwait(H);
      if (sdo_en !== 1'b0) oeb++;
    end
    sclk = 1'b0;
    hwait(H);
    chk("R9 ignored while deselected", cfg_regs, model_flat());
    chk("R9 oe low while deselected", {144'd0, 32'(oeb)}, 176'd0);

    // random mix
    for (int n = 0; n < 80; n++) begin
      logic [6:0] a;
      logic rw;
      logic [7:0] wd, e;
      a  = 7'($urandom_range(0, 26));
      rw = 1'($urandom_range(0, 1));
      wd = 8'($urandom_range(0, 255));
      status_in = 8'($urandom_range(0, 255));
      e = exp_read(a);
      frame(a, rw, wd, 16, rd, oeb);
      if (rw) chk("R4 random read", {168'd0, rd}, {168'd0, e});
      chk("R3 random bank", cfg_regs, model_flat());
      chk("R8 random oe window", {144'd0, 32'(oeb)}, 176'd0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule